// File: doc/BRIEF.md
# Interrupt Redirection Table Register Block

This block holds the programmable routing table of an interrupt controller together with its identification and version registers. Software on a 32-bit bus never addresses these registers directly. It first writes a register number into an index register, and then reads or writes the selected register through a single data window. The table has one 64-bit entry per interrupt input. Each entry is reached as two consecutive 32-bit register numbers, one for each half, and a write to one half is merged into the entry without touching the other half.

The whole table is exported as a flat vector, so the dispatch logic downstream can read every entry at once. A one-cycle update pulse, with the number of the entry that changed, is raised after each accepted table write, so that the dispatch logic knows to rescan its pending inputs. Reads are combinational and have no side effects. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the index register and the identification register are zero, every table entry holds 64'h0000_0000_0001_0000 (only the mask bit, bit 16, set), and the update pulse is low.
- R2: A write to bus offset 0x00 stores bits 7:0 of the write data in the index register. A read of offset 0x00 returns that value zero-extended to 32 bits. The index changes only on such a write.
- R3: Only bus address bits 7:0 are decoded, so the higher address bits have no effect. Offsets other than 0x00 and 0x10 read as zero, and writes to them change nothing.
- R4: Register number 0x00 through the window (offset 0x10) is the identification register. A write keeps only data bits 31:24, and a read returns the stored byte in bits 31:24 with all other bits zero.
- R5: Register number 0x01 reads 0x0017_0011: 0x11 in bits 7:0 and the entry count minus one (0x17) in bits 23:16. Register number 0x02 and numbers 0x03 to 0x0F read zero. Writes to numbers 0x01 to 0x0F change nothing and raise no update pulse.
- R6: Register number 0x10+2n selects bits 31:0 of table entry n, and number 0x11+2n selects bits 63:32 of the same entry, for n from 0 to 23.
- R7: A window write to one half of an entry replaces only that half. The other half keeps its value.
- R8: The update pulse is high for exactly the one cycle after the clock edge that accepts a table write. During that cycle the entry-number output carries n. Writes that do not reach the table raise no pulse.
- R9: Register numbers 0x40 and above, which decode to entry 24 or higher, read as zero, change nothing when written, and raise no update pulse.
- R10: The read data is valid in the same cycle as the read strobe and is zero when no read strobe is present. A read does not change the index register or the table.
- R11: Table entry n appears on the flat table output at bits 64n+63 down to 64n, updated by the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, data returned combinationally |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| tbl_upd | output | 1 | One-cycle pulse after a table half write |
| tbl_upd_idx | output | ENT_IDX_W (5) | Entry number written, valid with tbl_upd |
| tbl_flat | output | NUM_ENT*64 (1536) | All table entries, entry n at bits 64n+63:64n |

## Verification
The assertions assume that the strobes are known values in every cycle from reset onward. They also assume that read and write strobes are not raised together, because the no-side-effect property of reads is stated only for read-only cycles. The bench drives every strobe to a defined level from time zero. Its tasks raise exactly one strobe per access and drop it before the following access, so back-to-back writes and reads never overlap. Index values are chosen to hit the identification, version, reserved, first-entry, last-entry and beyond-table regions on both halves.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and decode types for the redirection register block.
// Assumes a 32-bit bus, 8-bit register numbers and 64-bit table entries.
package irq_route_pkg;
    localparam int          DATA_W      = 32;
    localparam int          ENT_W       = 64;
    localparam int          SEL_W       = 8;
    localparam logic [7:0]  OFF_INDEX   = 8'h00;
    localparam logic [7:0]  OFF_WINDOW  = 8'h10;
    localparam logic [7:0]  NUM_ID      = 8'h00;
    localparam logic [7:0]  NUM_VER     = 8'h01;
    localparam logic [7:0]  NUM_TBL0    = 8'h10;
    localparam logic [7:0]  VER_CODE    = 8'h11;
    localparam int          MASK_BIT    = 16;
    localparam logic [63:0] ENT_RST_VAL = 64'h1 << MASK_BIT;

    // Window target chosen by the current register number
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ID   = 2'd1,
        TGT_VER  = 2'd2,
        TGT_TBL  = 2'd3
    } tgt_e;
endpackage

// File: rtl/irq_route_decode.sv
`timescale 1ns/1ps
// Module: irq_route_decode
// Turns the low address byte and the register number into a window target,
// an entry number and a half select. Purely combinational.
// Assumes NUM_ENT entries fit in the 8-bit register number space (NUM_ENT <= 120).
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_ENT   = 24,
    parameter int ENT_IDX_W = 5
) (
    input  logic [7:0]           off,
    input  logic [SEL_W-1:0]     sel_num,
    output logic                 hit_index,
    output logic                 hit_window,
    output tgt_e                 tgt,
    output logic [ENT_IDX_W-1:0] ent_num,
    output logic                 upper_half
);
    localparam logic [6:0] NUM_ENT_L = 7'(NUM_ENT);

    logic [7:0] rel;
    logic [6:0] ent_wide;

    // Offset decode: only the two live offsets are recognised
    always_comb begin
        hit_index  = (off == OFF_INDEX);
        hit_window = (off == OFF_WINDOW);
    end

    // Register-number decode into target, entry number and half
    always_comb begin
        rel        = sel_num - NUM_TBL0;
        ent_wide   = rel[7:1];
        ent_num    = ent_wide[ENT_IDX_W-1:0];
        upper_half = sel_num[0];
        if (sel_num == NUM_ID)
            tgt = TGT_ID;
        else if (sel_num == NUM_VER)
            tgt = TGT_VER;
        else if (sel_num >= NUM_TBL0 && ent_wide < NUM_ENT_L)
            tgt = TGT_TBL;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/irq_route_entry.sv
`timescale 1ns/1ps
// Module: irq_route_entry
// One 64-bit table entry held as two independently written 32-bit halves.
// Assumes at most one of the half-write enables is high in a cycle.
module irq_route_entry
    import irq_route_pkg::*;
#(
    parameter logic [ENT_W-1:0] RST_VAL = ENT_RST_VAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [ENT_W-1:0]  ent_q
);
    // Half-merge storage: each enable replaces only its own half
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= RST_VAL;
        end else begin
            if (wr_lo) ent_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) ent_q[ENT_W-1:DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/irq_route_rdmux.sv
`timescale 1ns/1ps
// Module: irq_route_rdmux
// Forms the combinational read data from the index, identification,
// version and selected table entry. Returns zero when no read is strobed.
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int NUM_ENT = 24
) (
    input  logic              rd,
    input  logic              hit_index,
    input  logic              hit_window,
    input  tgt_e              tgt,
    input  logic              upper_half,
    input  logic [SEL_W-1:0]  sel_num,
    input  logic [7:0]        id_q,
    input  logic [ENT_W-1:0]  ent_data,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] VER_WORD =
        {8'h00, 8'(NUM_ENT - 1), 8'h00, VER_CODE};

    logic [DATA_W-1:0] win_data;

    // Window data by target
    always_comb begin
        unique case (tgt)
            TGT_ID:  win_data = {id_q, 24'h0};
            TGT_VER: win_data = VER_WORD;
            TGT_TBL: win_data = upper_half ? ent_data[ENT_W-1:DATA_W]
                                           : ent_data[DATA_W-1:0];
            default: win_data = '0;
        endcase
    end

    // Final read data by offset, gated by the read strobe
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (hit_index)
                rdata = {{(DATA_W-SEL_W){1'b0}}, sel_num};
            else if (hit_window)
                rdata = win_data;
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
// Module: irq_route_regs (top)
// Indirect register block: an index register at offset 0x00 selects the
// register seen through the window at offset 0x10. Holds the identification
// byte, a fixed version word and NUM_ENT 64-bit redirection entries, and
// pulses tbl_upd one cycle after each accepted table write.
// Assumes bus_rd and bus_wr are not raised in the same cycle.
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_ENT   = 24,
    parameter int ADDR_W    = 12,
    parameter int ENT_IDX_W = $clog2(NUM_ENT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     tbl_upd,
    output logic [ENT_IDX_W-1:0]     tbl_upd_idx,
    output logic [NUM_ENT*ENT_W-1:0] tbl_flat
);
    logic [SEL_W-1:0]     sel_q;
    logic [7:0]           id_q;
    logic                 hit_index;
    logic                 hit_window;
    tgt_e                 tgt;
    logic [ENT_IDX_W-1:0] ent_num;
    logic                 upper_half;
    logic                 tbl_wr;
    logic [ENT_W-1:0]     ent_data;
    logic [ENT_W-1:0]     ent_q [NUM_ENT];
    logic                 addr_unused;

    assign addr_unused = ^bus_addr[ADDR_W-1:8];

    irq_route_decode #(
        .NUM_ENT   (NUM_ENT),
        .ENT_IDX_W (ENT_IDX_W)
    ) u_dec (
        .off        (bus_addr[7:0]),
        .sel_num    (sel_q),
        .hit_index  (hit_index),
        .hit_window (hit_window),
        .tgt        (tgt),
        .ent_num    (ent_num),
        .upper_half (upper_half)
    );

    assign tbl_wr = bus_wr && hit_window && (tgt == TGT_TBL);

    // Index register: loaded only by writes to the index offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (bus_wr && hit_index)
            sel_q <= bus_wdata[SEL_W-1:0];
    end

    // Identification register: keeps only the top data byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (bus_wr && hit_window && tgt == TGT_ID)
            id_q <= bus_wdata[DATA_W-1:DATA_W-8];
    end

    // Update pulse and entry number for the dispatch rescan
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_upd     <= 1'b0;
            tbl_upd_idx <= '0;
        end else begin
            tbl_upd <= tbl_wr;
            if (tbl_wr) tbl_upd_idx <= ent_num;
        end
    end

    // One storage slice per entry, with its half-write enables
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        logic hit;
        assign hit = tbl_wr && (ent_num == ENT_IDX_W'(g));
        irq_route_entry #(
            .RST_VAL (ENT_RST_VAL)
        ) u_ent (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (hit && !upper_half),
            .wr_hi (hit && upper_half),
            .wdata (bus_wdata),
            .ent_q (ent_q[g])
        );
        assign tbl_flat[g*ENT_W +: ENT_W] = ent_q[g];
    end

    // Entry selection for reads
    always_comb begin
        ent_data = '0;
        for (int i = 0; i < NUM_ENT; i++)
            if (ent_num == ENT_IDX_W'(i)) ent_data = ent_q[i];
    end

    irq_route_rdmux #(
        .NUM_ENT (NUM_ENT)
    ) u_rd (
        .rd         (bus_rd),
        .hit_index  (hit_index),
        .hit_window (hit_window),
        .tgt        (tgt),
        .upper_half (upper_half),
        .sel_num    (sel_q),
        .id_q       (id_q),
        .ent_data   (ent_data),
        .rdata      (bus_rdata)
    );
endmodule

// File: rtl/irq_route_regs_chk.sv
`timescale 1ns/1ps
// Module: irq_route_regs_chk
// Property checker bound to irq_route_regs. Observes ports and the index register.
module irq_route_regs_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_ENT = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [7:0]               off,
    input logic [SEL_W-1:0]         sel_q,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic                     tbl_upd,
    input logic [NUM_ENT*ENT_W-1:0] tbl_flat
);
    localparam logic [8:0] TBL_END = 9'(16 + 2 * NUM_ENT);

    logic in_tbl;
    assign in_tbl = (sel_q >= 8'h10) && ({1'b0, sel_q} < TBL_END);

    AST_UPD_AFTER_TBL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == 8'h10 && in_tbl) |=> tbl_upd);  // R8

    AST_UPD_ONLY_TBL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && off == 8'h10 && in_tbl) |=> !tbl_upd);  // R9

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && off == 8'h00) |=> $stable(sel_q));  // R2

    AST_READ_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> ($stable(tbl_flat) && $stable(sel_q)));  // R10

    AST_VERSION_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && off == 8'h10 && sel_q == 8'h01)
            |-> bus_rdata == {8'h00, 8'(NUM_ENT - 1), 8'h00, 8'h11});  // R5

    AST_DEAD_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (off != 8'h00 && off != 8'h10) |-> bus_rdata == '0);  // R3

    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> bus_rdata == '0);  // R10
endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_ENT(NUM_ENT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .off       (bus_addr[7:0]),
    .sel_q     (sel_q),
    .bus_rdata (bus_rdata),
    .tbl_upd   (tbl_upd),
    .tbl_flat  (tbl_flat)
);

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
// Directed bench for irq_route_regs: one task per scenario, each self-checking.
module irq_route_regs_tb;
    localparam int NUM_ENT = 24;
    localparam int ADDR_W  = 12;
    localparam int IW      = 5;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_wr = 1'b0;
    logic                  bus_rd = 1'b0;
    logic [ADDR_W-1:0]     bus_addr = '0;
    logic [31:0]           bus_wdata = '0;
    logic [31:0]           bus_rdata;
    logic                  tbl_upd;
    logic [IW-1:0]         tbl_upd_idx;
    logic [NUM_ENT*64-1:0] tbl_flat;

    int   n_tests = 0;
    int   n_fail  = 0;
    logic done    = 1'b0;
    logic          last_upd;
    logic [IW-1:0] last_idx;

    always #2.5 clk = ~clk;

    irq_route_regs #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .tbl_upd (tbl_upd), .tbl_upd_idx (tbl_upd_idx), .tbl_flat (tbl_flat)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bw(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        last_upd = tbl_upd;
        last_idx = tbl_upd_idx;
    endtask

    task automatic br(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] num, output logic [31:0] d);
        bw(12'h000, {24'h0, num});
        br(12'h010, d);
    endtask

    task automatic reg_wr(input logic [7:0] num, input logic [31:0] v);
        bw(12'h000, {24'h0, num});
        bw(12'h010, v);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic        bad = 1'b0;
        chk("R1 upd low after reset", 64'(tbl_upd), 64'd0);
        br(12'h000, d);  chk("R1 index reset", 64'(d), 64'd0);
        br(12'h010, d);  chk("R1 id reset", 64'(d), 64'd0);
        for (int i = 0; i < NUM_ENT; i++)
            if (tbl_flat[i*64 +: 64] !== 64'h10000) bad = 1'b1;
        chk("R1 all entries mask only", 64'(bad), 64'd0);
        reg_rd(8'h3E, d); chk("R1 entry23 low half", 64'(d), 64'h10000);
        reg_rd(8'h3F, d); chk("R1 entry23 high half", 64'(d), 64'd0);
    endtask

    task automatic t_index();
        logic [31:0] d;
        bw(12'h000, 32'h0000_005A); br(12'h000, d);
        chk("R2 index readback", 64'(d), 64'h5A);
        bw(12'h000, 32'hFFFF_FF37); br(12'h000, d);
        chk("R2 index keeps low byte", 64'(d), 64'h37);
        br(12'h010, d); br(12'h000, d);
        chk("R2 index unchanged by window read", 64'(d), 64'h37);
    endtask

    task automatic t_id();
        logic [31:0] d;
        reg_wr(8'h00, 32'hAB12_3456);
        br(12'h010, d);
        chk("R4 id keeps top byte", 64'(d), 64'hAB00_0000);
        chk("R4 no upd on id write", 64'(last_upd), 64'd0);
    endtask

    task automatic t_version();
        logic [31:0] d;
        logic [NUM_ENT*64-1:0] snap;
        snap = tbl_flat;
        reg_rd(8'h01, d); chk("R5 version word", 64'(d), 64'h0017_0011);
        reg_wr(8'h01, 32'hFFFF_FFFF);
        chk("R5 no upd on version write", 64'(last_upd), 64'd0);
        br(12'h010, d); chk("R5 version after write", 64'(d), 64'h0017_0011);
        reg_wr(8'h02, 32'h1234_5678); br(12'h010, d);
        chk("R5 number 2 reads zero", 64'(d), 64'd0);
        reg_wr(8'h0F, 32'h1234_5678); br(12'h010, d);
        chk("R5 number 0x0F reads zero", 64'(d), 64'd0);
        chk("R5 table untouched", 64'(tbl_flat == snap), 64'd1);
        reg_rd(8'h00, d); chk("R5 id untouched", 64'(d), 64'hAB00_0000);
    endtask

    task automatic t_offsets();
        logic [31:0] d;
        logic [NUM_ENT*64-1:0] snap;
        snap = tbl_flat;
        bw(12'h004, 32'hDEAD_BEEF); br(12'h004, d);
        chk("R3 dead offset reads zero", 64'(d), 64'd0);
        bw(12'h100, 32'h0000_0011); br(12'h000, d);
        chk("R3 high addr bits ignored on index", 64'(d), 64'h11);
        bw(12'hF10, 32'hCAFE_0001); br(12'h210, d);
        chk("R3 aliased window write", 64'(d), 64'hCAFE_0001);
        chk("R3 aliased write strobe", 64'(tbl_upd_idx), 64'd0);
        bw(12'h014, 32'h5555_5555); br(12'h010, d);
        chk("R3 write to 0x14 ignored", 64'(d), 64'hCAFE_0001);
        chk("R11 entry0 after alias write", tbl_flat[0 +: 64],
            {32'hCAFE_0001, snap[31:0]});
    endtask

    task automatic t_table();
        logic [31:0] d;
        reg_wr(8'h1A, 32'h0000_A5C3);
        chk("R8 upd after low write", 64'(last_upd), 64'd1);
        chk("R8 upd entry number", 64'(last_idx), 64'd5);
        reg_wr(8'h1B, 32'hFF00_0000);
        chk("R8 upd after high write", 64'(last_upd), 64'd1);
        reg_rd(8'h1A, d); chk("R6 entry5 low", 64'(d), 64'h0000_A5C3);
        reg_rd(8'h1B, d); chk("R6 entry5 high", 64'(d), 64'hFF00_0000);
        chk("R11 entry5 flat", tbl_flat[5*64 +: 64], 64'hFF00_0000_0000_A5C3);
        reg_wr(8'h3F, 32'h0102_0304);
        chk("R8 upd entry 23", 64'(last_idx), 64'd23);
        chk("R11 entry23 flat", tbl_flat[23*64 +: 64], 64'h0102_0304_0001_0000);
        @(negedge clk);
        chk("R8 upd lasts one cycle", 64'(tbl_upd), 64'd0);
    endtask

    task automatic t_merge();
        logic [31:0] d;
        reg_wr(8'h10, 32'h0000_0031);
        chk("R7 low write keeps high", tbl_flat[0 +: 64], 64'hCAFE_0001_0000_0031);
        reg_wr(8'h11, 32'h0F00_0000);
        chk("R7 high write keeps low", tbl_flat[0 +: 64], 64'h0F00_0000_0000_0031);
        reg_rd(8'h10, d); chk("R7 low readback", 64'(d), 64'h31);
    endtask

    task automatic t_range();
        logic [31:0] d;
        logic [NUM_ENT*64-1:0] snap;
        snap = tbl_flat;
        reg_wr(8'h40, 32'h7777_7777);
        chk("R9 no upd at 0x40", 64'(last_upd), 64'd0);
        br(12'h010, d); chk("R9 0x40 reads zero", 64'(d), 64'd0);
        reg_wr(8'h41, 32'h7777_7777);
        chk("R9 no upd at 0x41", 64'(last_upd), 64'd0);
        reg_wr(8'hFF, 32'h7777_7777);
        br(12'h010, d); chk("R9 0xFF reads zero", 64'(d), 64'd0);
        chk("R9 table untouched", 64'(tbl_flat == snap), 64'd1);
    endtask

    task automatic t_read();
        logic [31:0] d1;
        logic [31:0] d2;
        logic [NUM_ENT*64-1:0] snap;
        bw(12'h000, 32'h0000_001B);
        snap = tbl_flat;
        br(12'h010, d1); br(12'h010, d2);
        chk("R10 repeat read equal", 64'(d2), 64'(d1));
        chk("R10 same-cycle read data", 64'(d1), 64'hFF00_0000);
        chk("R10 table stable over reads", 64'(tbl_flat == snap), 64'd1);
        @(negedge clk); bus_addr = 12'h010; #1;
        chk("R10 zero without read strobe", 64'(bus_rdata), 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_id();
        t_version();
        t_offsets();
        t_table();
        t_merge();
        t_range();
        t_read();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule